// File: doc/BRIEF.md
# Linked-List Channel DMA Engine

This block is an I/O channel that carries out a chain of transfers without help from the processor. Software writes the byte address of the first command word and pulses a start input. The engine becomes a bus master and fetches the four-word command word. It then moves the requested number of bytes between memory and a byte-wide device port, stepping the memory address up by one and the remaining count down by one per byte. When a word finishes, the engine follows that word's next pointer to the following word. Because each word carries its own buffer address, one device block can be scattered over several separate memory buffers, or gathered from them.

The engine interrupts only once, at the end of the chain or when it meets a faulty command word. A status view gives busy, done and error. Done and error stay set until software clears them with a one-cycle clear pulse, one pulse input per bit. A command word can also mark the end of a physical device block, and that mark is signalled to the device on the last byte of the word.

States of the controller and their transitions:
- IDLE: goes to FETCH on start.
- FETCH: reads command word parts 0 to 3. After part 3 is granted it goes to CHECK.
- CHECK: goes to FAULT when the count is zero. Otherwise it goes to MRD when the direction is to the device, or to DRX when it is from the device.
- MRD: reads a memory byte and goes to DTX on grant.
- DTX: offers the byte to the device. When the device takes it, the engine goes to NEXT after the last byte and back to MRD otherwise.
- DRX: waits for a device byte and goes to MWR when one arrives.
- MWR: writes the byte to memory. On grant it goes to NEXT after the last byte and back to DRX otherwise.
- NEXT: goes to FINISH when end-of-chain is set and to FETCH at the next pointer otherwise.
- FINISH and FAULT: go back to IDLE, setting done or error.

Top module: `chan_dma`

## Requirements
- R1: After reset, busy, done, error, irq, bus_req, dev_tx_valid, dev_rx_ready and dev_blk_end are all low.
- R2: A start pulse in idle latches cpu_pc. The engine then reads the four command-word parts at cpu_pc, +4, +8 and +12 as 32-bit words. Part 0 holds bit 0 = direction (1 = memory to device), bit 1 = end of chain and bit 2 = end of physical block. Part 1 is the buffer byte address, part 2 is the byte count (low 16 bits) and part 3 is the next-word address.
- R3: With direction 1, the bytes at buffer address, address+1, up to address+count-1 are sent on the device transmit port in that order, exactly count bytes. A memory byte read takes mem_rdata[7:0].
- R4: With direction 0, count bytes taken from the device receive port are written to ascending memory addresses starting at the buffer address, and nothing outside that range is written.
- R5: The engine follows next pointers until it completes a word with end of chain set. Done rises exactly once, after the last byte of the chain, and irq is high while done or error is set.
- R6: A command word with a zero count moves no byte. It sets error, leaves done clear, and ends the chain.
- R7: Done and error each stay set until their own clear pulse. Clearing one leaves the other unchanged.
- R8: While dev_tx_valid is high and dev_tx_ready is low, dev_tx_valid stays high and dev_tx_data stays stable. A stalling device loses no byte.
- R9: bus_req stays high with a stable mem_addr until bus_gnt is seen. At most one of bus_req, dev_tx_valid and dev_rx_ready is high at a time.
- R10: dev_blk_end is high with the last byte handshake of a word whose end-of-block bit is set, and at no other byte.
- R11: A start pulse while busy is ignored, and the running chain completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_start | input | 1 | Start pulse |
| cpu_pc | input | 32 | Address of first command word |
| cpu_clr_done | input | 1 | Clear pulse for done |
| cpu_clr_err | input | 1 | Clear pulse for error |
| stat_busy | output | 1 | Chain running |
| stat_done | output | 1 | Chain completed (sticky) |
| stat_err | output | 1 | Faulty command word seen (sticky) |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; the access completes in the granted cycle |
| mem_addr | output | 32 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 32 | Memory read data |
| dev_tx_valid | output | 1 | Byte offered to device |
| dev_tx_ready | input | 1 | Device accepts byte |
| dev_tx_data | output | 8 | Byte to device |
| dev_rx_valid | input | 1 | Device offers byte |
| dev_rx_ready | output | 1 | Engine accepts byte |
| dev_rx_data | input | 8 | Byte from device |
| dev_blk_end | output | 1 | Last byte of a physical block |

## Verification
Busy rises one cycle after start is sampled. Done or error, and the fall of busy, appear together one cycle after the FINISH or FAULT state. The bench therefore waits for busy to fall, samples at the falling edge that follows, and checks all of the chain's results there. Device and memory bytes are logged at each clock edge where the handshake completes, so random grant and ready stalls move when each byte arrives but not what is compared. The sweep covers every count from 1 to 6 under four stall patterns, with expected bytes computed from the fill formula.

// File: rtl/chan_pkg.sv
package chan_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_MRD, ST_DTX,
        ST_DRX, ST_MWR, ST_NEXT, ST_FINISH, ST_FAULT
    } chan_state_t;

    typedef struct packed {
        logic eob;
        logic eoc;
        logic dir;
    } cw_flags_t;
endpackage

// File: rtl/chan_cursor.sv
module chan_cursor #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            cnt  <= '0;
        end else if (load) begin
            addr <= load_addr;
            cnt  <= load_cnt;
        end else if (step) begin
            addr <= addr + AW'(1);
            cnt  <= cnt - CW'(1);
        end
    end

    assign last = (cnt == CW'(1));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt != '0)); // R3
endmodule

// File: rtl/chan_status.sv
module chan_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_err,
    input  logic clr_done,
    input  logic clr_err,
    output logic done,
    output logic err,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (set_done)      done <= 1'b1;
            else if (clr_done) done <= 1'b0;
            if (set_err)       err  <= 1'b1;
            else if (clr_err)  err  <= 1'b0;
        end
    end

    assign irq = done | err;

    AST_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !set_done) |=> !done); // R7
    AST_ERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_err) |=> err); // R7
endmodule

// File: rtl/chan_dma.sv
module chan_dma
    import chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_start,
    input  logic [AW-1:0] cpu_pc,
    input  logic          cpu_clr_done,
    input  logic          cpu_clr_err,
    output logic          stat_busy,
    output logic          stat_done,
    output logic          stat_err,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [BW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    output logic          dev_tx_valid,
    input  logic          dev_tx_ready,
    output logic [BW-1:0] dev_tx_data,
    input  logic          dev_rx_valid,
    output logic          dev_rx_ready,
    input  logic [BW-1:0] dev_rx_data,
    output logic          dev_blk_end
);
    localparam int PARTS = 4;
    localparam int IW    = $clog2(PARTS);

    chan_state_t   state, nxt;
    logic [AW-1:0] pc_q, buf_q, next_q;
    logic [CW-1:0] cnt_q;
    cw_flags_t     flags_q;
    logic [IW-1:0] idx_q;
    logic [BW-1:0] byte_q;

    logic          cur_load, cur_step, cur_last;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_cnt;
    logic          set_done, set_err;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cpu_start) nxt = ST_FETCH;
            ST_FETCH:  if (bus_gnt && idx_q == IW'(PARTS-1)) nxt = ST_CHECK;
            ST_CHECK:  if (cnt_q == '0)    nxt = ST_FAULT;
                       else if (flags_q.dir) nxt = ST_MRD;
                       else                  nxt = ST_DRX;
            ST_MRD:    if (bus_gnt) nxt = ST_DTX;
            ST_DTX:    if (dev_tx_ready) nxt = cur_last ? ST_NEXT : ST_MRD;
            ST_DRX:    if (dev_rx_valid) nxt = ST_MWR;
            ST_MWR:    if (bus_gnt) nxt = cur_last ? ST_NEXT : ST_DRX;
            ST_NEXT:   nxt = flags_q.eoc ? ST_FINISH : ST_FETCH;
            ST_FINISH: nxt = ST_IDLE;
            ST_FAULT:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // command word fetch and byte holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            buf_q   <= '0;
            next_q  <= '0;
            cnt_q   <= '0;
            flags_q <= '0;
            idx_q   <= '0;
            byte_q  <= '0;
        end else begin
            if (state == ST_IDLE && cpu_start) begin
                pc_q  <= cpu_pc;
                idx_q <= '0;
            end
            if (state == ST_FETCH && bus_gnt) begin
                idx_q <= idx_q + IW'(1);
                unique case (idx_q)
                    2'd0:    flags_q <= cw_flags_t'(mem_rdata[2:0]);
                    2'd1:    buf_q   <= mem_rdata;
                    2'd2:    cnt_q   <= mem_rdata[CW-1:0];
                    default: next_q  <= mem_rdata;
                endcase
            end
            if (state == ST_NEXT && !flags_q.eoc) begin
                pc_q  <= next_q;
                idx_q <= '0;
            end
            if (state == ST_MRD && bus_gnt)      byte_q <= mem_rdata[BW-1:0];
            if (state == ST_DRX && dev_rx_valid) byte_q <= dev_rx_data;
        end
    end

    // outputs
    always_comb begin
        bus_req      = (state == ST_FETCH) || (state == ST_MRD) || (state == ST_MWR);
        mem_we       = (state == ST_MWR);
        mem_addr     = (state == ST_FETCH) ? pc_q + AW'({idx_q, 2'b00}) : cur_addr;
        mem_wdata    = byte_q;
        dev_tx_valid = (state == ST_DTX);
        dev_tx_data  = byte_q;
        dev_rx_ready = (state == ST_DRX);
        dev_blk_end  = ((state == ST_DTX) || (state == ST_DRX)) && cur_last && flags_q.eob;
        cur_load     = (state == ST_CHECK) && (cnt_q != '0);
        cur_step     = ((state == ST_DTX) && dev_tx_ready) || ((state == ST_MWR) && bus_gnt);
        set_done     = (state == ST_FINISH);
        set_err      = (state == ST_FAULT);
        stat_busy    = (state != ST_IDLE);
    end

    chan_cursor #(.AW(AW), .CW(CW)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cur_load),
        .load_addr(buf_q),
        .load_cnt (cnt_q),
        .step     (cur_step),
        .addr     (cur_addr),
        .cnt      (cur_cnt),
        .last     (cur_last)
    );

    chan_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_done(set_done),
        .set_err (set_err),
        .clr_done(cpu_clr_done),
        .clr_err (cpu_clr_err),
        .done    (stat_done),
        .err     (stat_err),
        .irq     (irq)
    );

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(mem_addr))); // R9
    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req, dev_tx_valid, dev_rx_ready})); // R9
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_tx_valid && !dev_tx_ready) |=> (dev_tx_valid && $stable(dev_tx_data))); // R8
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_done) |-> !stat_busy); // R5
    AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_tx_valid || dev_rx_ready) |-> (cur_cnt != '0)); // R6
endmodule

// File: tb/chan_dma_tb.sv
module chan_dma_tb;
    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cpu_start, cpu_clr_done, cpu_clr_err;
    logic [31:0] cpu_pc;
    logic        stat_busy, stat_done, stat_err, irq;
    logic        bus_req, bus_gnt, mem_we;
    logic [31:0] mem_addr, mem_rdata;
    logic [7:0]  mem_wdata;
    logic        dev_tx_valid, dev_tx_ready, dev_rx_valid, dev_rx_ready, dev_blk_end;
    logic [7:0]  dev_tx_data, dev_rx_data;

    chan_dma u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_start(cpu_start), .cpu_pc(cpu_pc),
        .cpu_clr_done(cpu_clr_done), .cpu_clr_err(cpu_clr_err),
        .stat_busy(stat_busy), .stat_done(stat_done), .stat_err(stat_err), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
        .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data),
        .dev_blk_end(dev_blk_end)
    );

    logic [7:0]  mem [0:255];
    logic [7:0]  tx_log [0:63];
    logic        blk_log [0:63];
    logic [7:0]  rx_src [0:63];
    int          tx_n, rx_i, rx_n, rxblk_pos, done_rises, hold_bad, bus_bad, wr_cnt;
    logic        prev_txstall, prev_busstall, done_q;
    logic [7:0]  prev_txd;
    logic [31:0] prev_addr;
    logic        gnt_mode, rdy_mode;
    logic [15:0] lfsr;
    int          n_chk, n_bad, cyc;

    assign mem_rdata = {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                        mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (bus_req && bus_gnt && mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if (dev_tx_valid && dev_tx_ready) begin
            tx_log[tx_n]  = dev_tx_data;
            blk_log[tx_n] = dev_blk_end;
            tx_n = tx_n + 1;
        end
        if (dev_rx_valid && dev_rx_ready) begin
            if (dev_blk_end) rxblk_pos = rx_i;
            rx_i = rx_i + 1;
        end
        if (prev_txstall && !(dev_tx_valid && dev_tx_data == prev_txd)) hold_bad = hold_bad + 1;
        prev_txstall = dev_tx_valid && !dev_tx_ready;
        prev_txd     = dev_tx_data;
        if (prev_busstall && !(bus_req && mem_addr == prev_addr)) bus_bad = bus_bad + 1;
        prev_busstall = bus_req && !bus_gnt;
        prev_addr     = mem_addr;
        if (stat_done && !done_q) done_rises = done_rises + 1;
        done_q = stat_done;
    end

    always @(negedge clk) begin
        lfsr         <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bus_gnt      <= !gnt_mode || lfsr[0];
        dev_tx_ready <= !rdy_mode || lfsr[3];
        dev_rx_valid <= (rx_i < rx_n) && (!rdy_mode || lfsr[5]);
        dev_rx_data  <= rx_src[rx_i];
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
    endtask

    task automatic put_cw(input int a, input int flg, input int buf_a, input int cnt, input int nx);
        put_word(a, flg);
        put_word(a + 4, buf_a);
        put_word(a + 8, cnt);
        put_word(a + 12, nx);
    endtask

    task automatic clear_logs();
        tx_n = 0; rx_i = 0; rxblk_pos = -1; done_rises = 0;
        for (int k = 0; k < 64; k++) blk_log[k] = 1'b0;
    endtask

    task automatic start_chain(input int pc);
        @(negedge clk);
        cpu_pc = pc; cpu_start = 1'b1;
        @(negedge clk);
        cpu_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && stat_busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clr(input logic d, input logic e);
        @(negedge clk);
        cpu_clr_done = d; cpu_clr_err = e;
        @(negedge clk);
        cpu_clr_done = 1'b0; cpu_clr_err = 1'b0;
    endtask

    task automatic fill_src();
        for (int k = 0; k < 64; k++) mem[8'h80 + k] = 8'(k * 7 + 3);
    endtask

    initial begin
        cyc = 0;
        for (;;) begin
            @(negedge clk);
            if (cyc > 150000) begin
                n_chk = n_chk + 1; n_bad = n_bad + 1;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int bad, mask;
        n_chk = 0; n_bad = 0; hold_bad = 0; bus_bad = 0; wr_cnt = 0;
        prev_txstall = 0; prev_busstall = 0; done_q = 0; prev_txd = 0; prev_addr = 0;
        lfsr = 16'hACE1; gnt_mode = 0; rdy_mode = 0; rx_n = 0;
        cpu_start = 0; cpu_pc = 0; cpu_clr_done = 0; cpu_clr_err = 0;
        for (int k = 0; k < 256; k++) mem[k] = 8'h00;
        for (int k = 0; k < 64; k++) rx_src[k] = 8'h40 + 8'(k);
        clear_logs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 busy", int'(stat_busy), 0);
        check("R1 flags", int'({stat_done, stat_err, irq}), 0);
        check("R1 bus/dev", int'({bus_req, dev_tx_valid, dev_rx_ready, dev_blk_end}), 0);
        rst_n = 1'b1;
        fill_src();

        // R2 R3 single word to device
        clear_logs();
        put_cw(8'h00, 3'b011, 8'h80, 5, 0);
        start_chain(8'h00);
        check("R2 busy after start", int'(stat_busy), 1);
        wait_idle();
        check("R3 byte count", tx_n, 5);
        bad = 0;
        for (int k = 0; k < 5; k++) if (tx_log[k] != 8'(k * 7 + 3)) bad++;
        check("R3 byte order", bad, 0);
        check("R5 done", int'({stat_done, stat_err, irq, stat_busy}), 4'b1010);

        // R7 independent clears
        clr(1'b0, 1'b1);
        check("R7 clr err keeps done", int'(stat_done), 1);
        clr(1'b1, 1'b0);
        check("R7 done cleared", int'({stat_done, irq}), 0);

        // R5 R8 R9 R10 gather chain with stalls
        clear_logs(); gnt_mode = 1; rdy_mode = 1;
        put_cw(8'h00, 3'b001, 8'h84, 3, 8'h30);
        put_cw(8'h30, 3'b101, 8'h90, 2, 8'h50);
        put_cw(8'h50, 3'b111, 8'hA0, 4, 0);
        start_chain(8'h00);
        wait_idle();
        check("R5 chain bytes", tx_n, 9);
        bad = 0;
        for (int k = 0; k < 3; k++) if (tx_log[k] != 8'((4 + k) * 7 + 3)) bad++;
        for (int k = 0; k < 2; k++) if (tx_log[3 + k] != 8'((16 + k) * 7 + 3)) bad++;
        for (int k = 0; k < 4; k++) if (tx_log[5 + k] != 8'((32 + k) * 7 + 3)) bad++;
        check("R5 gather contents", bad, 0);
        check("R5 one done rise", done_rises, 1);
        mask = 0;
        for (int k = 0; k < 9; k++) if (blk_log[k]) mask |= (1 << k);
        check("R10 block end positions", mask, (1 << 4) | (1 << 8));
        check("R8 tx hold", hold_bad, 0);
        check("R9 bus hold", bus_bad, 0);
        clr(1'b1, 1'b1);

        // R4 scatter from device
        clear_logs(); rx_n = 5; wr_cnt = 0;
        for (int k = 0; k < 64; k++) mem[8'hC0 + k] = 8'h5A;
        put_cw(8'h00, 3'b000, 8'hC4, 3, 8'h20);
        put_cw(8'h20, 3'b110, 8'hD8, 2, 0);
        start_chain(8'h00);
        wait_idle();
        bad = 0;
        for (int k = 0; k < 3; k++) if (mem[8'hC4 + k] != 8'h40 + 8'(k)) bad++;
        for (int k = 0; k < 2; k++) if (mem[8'hD8 + k] != 8'h43 + 8'(k)) bad++;
        check("R4 scatter contents", bad, 0);
        check("R4 neighbours", int'({mem[8'hC3], mem[8'hC7], mem[8'hD7], mem[8'hDA]}), 32'h5A5A5A5A);
        check("R4 write count", wr_cnt, 5);
        check("R10 rx block end", rxblk_pos, 4);
        check("R5 rx done", int'({stat_done, stat_err}), 2'b10);
        clr(1'b1, 1'b1);
        rx_n = 0;

        // R6 zero count mid-chain
        clear_logs(); gnt_mode = 0; rdy_mode = 0;
        put_cw(8'h00, 3'b001, 8'h80, 2, 8'h40);
        put_cw(8'h40, 3'b011, 8'h88, 0, 0);
        start_chain(8'h00);
        wait_idle();
        check("R6 bytes before fault", tx_n, 2);
        check("R6 err set done clear", int'({stat_done, stat_err, irq}), 3'b011);
        clr(1'b1, 1'b0);
        check("R7 clr done keeps err", int'(stat_err), 1);
        clr(1'b0, 1'b1);
        check("R7 err cleared", int'({stat_err, irq}), 0);

        // R11 start while busy
        clear_logs(); gnt_mode = 1;
        put_cw(8'h00, 3'b011, 8'h80, 8, 0);
        put_cw(8'h60, 3'b011, 8'hF0, 3, 0);
        start_chain(8'h00);
        repeat (5) @(negedge clk);
        start_chain(8'h60);
        wait_idle();
        check("R11 bytes of first chain", tx_n, 8);
        bad = 0;
        for (int k = 0; k < 8; k++) if (tx_log[k] != 8'(k * 7 + 3)) bad++;
        check("R11 contents", bad, 0);
        check("R11 one done", done_rises, 1);
        clr(1'b1, 1'b1);

        // R3 sweep: counts and stall patterns
        for (int m = 0; m < 4; m++) begin
            for (int c = 1; c <= 6; c++) begin
                clear_logs();
                gnt_mode = m[0]; rdy_mode = m[1];
                put_cw(8'h00, 3'b011, 8'h80 + c, c, 0);
                start_chain(8'h00);
                wait_idle();
                bad = (tx_n != c) ? 1 : 0;
                for (int k = 0; k < c; k++) if (tx_log[k] != 8'((c + k) * 7 + 3)) bad++;
                check("R3 sweep", bad, 0);
                check("R5 sweep done", int'({stat_done, done_rises[0]}), 2'b11);
                clr(1'b1, 1'b1);
            end
        end
        check("R8 tx hold sweep", hold_bad, 0);
        check("R9 bus hold sweep", bus_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule